// File: doc/BRIEF.md
# Reset-Synchronized Three-Phase PWM Generator

This timer block drives three complementary phase pairs for a brushless motor bridge from one shared up-counter. A period register sets the length of the PWM cycle: the counter climbs from zero and clears when it matches the period. Each phase has its own compare register. Within a cycle the positive output of a phase sits at its inactive level until the counter reaches that phase's compare value, and then turns active. The negative output is always the exact complement, with no dead time. A separate toggle output flips once per PWM cycle.

A small control state machine has two states. In HALT the counter is frozen and the register write port is open. In COUNT the counter advances on every cycle where the prescaler enable `tick` is high, and all writes are dropped. The transition HALT→COUNT is taken at a clock edge where `run` is high. The transition COUNT→HALT is taken at an edge where `run` is low. Software loads the counter (normally to zero), the period, the compares and the control word while halted, and then raises `run`.

Write addresses on `wr_addr`: 0 period, 1/2/3 compare of phase 0/1/2, 4 control word, 5 counter load. Control word bits: [0] toggle enable, [1] positive active level (1 = high), [2] negative active level (1 = high), [5:3] positive pin enables for phases 0..2, [8:6] negative pin enables for phases 0..2.

Top module: `rspwm_gen`

## Requirements
- R1: In COUNT, a tick with counter equal to the period clears the counter to 0; any other tick adds 1.
- R2: The positive output of a phase is active exactly when counter ≥ compare and compare ≠ period. The negative output of that phase is active exactly when the positive is inactive.
- R3: A compare of 0 keeps the positive output active for the whole cycle. A compare equal to the period keeps it inactive for the whole cycle.
- R4: The counter changes only on clock edges where the controller is in COUNT and `tick` is high.
- R5: The state machine enters COUNT on an edge where `run` is high and returns to HALT on an edge where `run` is low. The counter holds while in HALT.
- R6: Register writes take effect at the next edge when the controller is in HALT. A write presented in COUNT has no effect.
- R7: A write to address 5 in HALT loads the counter with `wr_data`.
- R8: The toggle output flips whenever the counter advances into a value equal to the period. When control bit 0 is 0, the toggle output reads 0.
- R9: The active level of all positive outputs follows control bit 1, and that of all negative outputs follows control bit 2 (1 = high, 0 = low).
- R10: A pin whose enable bit is 0 drives the inactive level of its group.
- R11: After reset: HALT, counter 0, all registers 0. Hence all six phase outputs are 1 and the toggle output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler clock-enable for the counter |
| run | input | 1 | Start bit; high counts, low halts |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..5) |
| wr_data | input | CNT_W | Write data |
| ph_p | output | 3 | Positive-phase outputs, phase 0 in bit 0 |
| ph_n | output | 3 | Negative-phase outputs, phase 0 in bit 0 |
| tgl_o | output | 1 | Cycle-synchronized toggle output |

## Verification
Directed runs set the compares to 0, to a middle value and to the period in one configuration. This separates the whole-cycle, mid-cycle and never-active cases of R2 and R3 on adjacent pins. A sparse and alternating `tick` pattern tells true prescaled counting apart from counting on every clock. Writes issued during COUNT, followed by observing an unchanged waveform, separate gated writes from ungated ones. Random rounds draw the period, the compares, the control word, the load value and the tick density at random, including a period of 0 and load values above the period. These rounds catch off-by-one errors in the clear and compare points, inverted level handling and swapped pin enables.

// File: rtl/rspwm_pkg.sv
package rspwm_pkg;
    typedef enum logic {
        S_HALT  = 1'b0,
        S_COUNT = 1'b1
    } run_state_t;

    localparam int unsigned NUM_PH = 3;

    localparam logic [2:0] A_PER  = 3'd0;
    localparam logic [2:0] A_CMP0 = 3'd1;
    localparam logic [2:0] A_CTL  = 3'd4;
    localparam logic [2:0] A_LOAD = 3'd5;

    localparam int unsigned C_TEN = 0;
    localparam int unsigned C_LVP = 1;
    localparam int unsigned C_LVN = 2;
    localparam int unsigned C_ENP = 3;
    localparam int unsigned C_ENN = C_ENP + NUM_PH;
    localparam int unsigned CTL_W = C_ENN + NUM_PH;
endpackage

// File: rtl/rspwm_regs.sv
module rspwm_regs
    import rspwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            halted,
    input  logic                            wr_en,
    input  logic [2:0]                      wr_addr,
    input  logic [CNT_W-1:0]                wr_data,
    output logic [CNT_W-1:0]                period,
    output logic [NUM_PH-1:0][CNT_W-1:0]    cmp,
    output logic [CTL_W-1:0]                ctl,
    output logic                            ld_en,
    output logic [CNT_W-1:0]                ld_val
);
    logic wr_ok;
    assign wr_ok  = wr_en && halted;
    assign ld_en  = wr_ok && (wr_addr == A_LOAD);
    assign ld_val = wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period <= '0;
            ctl    <= '0;
        end else if (wr_ok) begin
            if (wr_addr == A_PER) period <= wr_data;
            if (wr_addr == A_CTL) ctl    <= wr_data[CTL_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_PH; g++) begin : g_cmp
        localparam logic [2:0] MY_ADDR = A_CMP0 + 3'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             cmp[g] <= '0;
            else if (wr_ok && wr_addr == MY_ADDR)   cmp[g] <= wr_data;
        end
    end

    // R6
    period_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> $stable(period));
    // R6
    ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> $stable(ctl));
endmodule

// File: rtl/rspwm_counter.sv
module rspwm_counter
    import rspwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             halted,
    output logic             tgl_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    run_state_t state, state_nxt;
    logic             adv;
    logic [CNT_W-1:0] cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_HALT;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_HALT:  if (run)  state_nxt = S_COUNT;
            S_COUNT: if (!run) state_nxt = S_HALT;
        endcase
    end

    assign halted  = (state == S_HALT);
    assign adv     = (state == S_COUNT) && tick;
    assign cnt_nxt = (cnt == period) ? '0 : cnt + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (ld_en) cnt <= ld_val;
        else if (adv)   cnt <= cnt_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           tgl_q <= 1'b0;
        else if (adv && cnt_nxt == period)    tgl_q <= ~tgl_q;
    end

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt == period) |=> (cnt == '0));
    // R4
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COUNT && !tick) |=> $stable(cnt));
    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HALT && !ld_en) |=> $stable(cnt));
    // R8
    tgl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(tgl_q));
endmodule

// File: rtl/rspwm_phase.sv
module rspwm_phase #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] period,
    input  logic             lvl_p,
    input  logic             lvl_n,
    input  logic             en_p,
    input  logic             en_n,
    output logic             out_p,
    output logic             out_n
);
    logic act;
    assign act   = (cnt >= cmp) && (cmp != period);
    assign out_p = (en_p && act)  ? lvl_p : ~lvl_p;
    assign out_n = (en_n && !act) ? lvl_n : ~lvl_n;

    // R2
    compl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_p && en_n && lvl_p == lvl_n) |-> (out_p != out_n));
    // R10
    pos_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_p |-> (out_p == ~lvl_p));
    // R10
    neg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_n |-> (out_n == ~lvl_n));
endmodule

// File: rtl/rspwm_gen.sv
module rspwm_gen
    import rspwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_PH-1:0] ph_p,
    output logic [NUM_PH-1:0] ph_n,
    output logic              tgl_o
);
    logic [CNT_W-1:0]             period, cnt, ld_val;
    logic [NUM_PH-1:0][CNT_W-1:0] cmp;
    logic [CTL_W-1:0]             ctl;
    logic                         ld_en, halted, tgl_q;

    rspwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .halted(halted),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .period(period), .cmp(cmp), .ctl(ctl),
        .ld_en(ld_en), .ld_val(ld_val)
    );

    rspwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .period(period), .ld_en(ld_en), .ld_val(ld_val),
        .cnt(cnt), .halted(halted), .tgl_q(tgl_q)
    );

    for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
        rspwm_phase #(.CNT_W(CNT_W)) u_ph (
            .clk(clk), .rst_n(rst_n),
            .cnt(cnt), .cmp(cmp[g]), .period(period),
            .lvl_p(ctl[C_LVP]), .lvl_n(ctl[C_LVN]),
            .en_p(ctl[C_ENP+g]), .en_n(ctl[C_ENN+g]),
            .out_p(ph_p[g]), .out_n(ph_n[g])
        );
    end

    assign tgl_o = tgl_q & ctl[C_TEN];

    // R8
    tgl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[C_TEN] |-> !tgl_o);
endmodule

// File: tb/tb_rspwm_gen.sv
`timescale 1ns/1ps
module tb_rspwm_gen;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0, run = 1'b0, wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [2:0]    ph_p, ph_n;
    logic          tgl_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state
    logic [W-1:0] m_per, m_cnt;
    logic [W-1:0] m_cmp [3];
    logic [8:0]   m_ctl;
    logic         m_tgl, m_cnting;

    always #2 clk = ~clk;

    rspwm_gen #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ph_p(ph_p), .ph_n(ph_n), .tgl_o(tgl_o)
    );

    function automatic logic [6:0] exp_out();
        logic [2:0] p, n;
        for (int i = 0; i < 3; i++) begin
            logic act;
            act  = (m_cnt >= m_cmp[i]) && (m_cmp[i] != m_per);
            p[i] = (m_ctl[3+i] && act)  ? m_ctl[1] : ~m_ctl[1];
            n[i] = (m_ctl[6+i] && !act) ? m_ctl[2] : ~m_ctl[2];
        end
        return {p, n, m_tgl & m_ctl[0]};
    endfunction

    task automatic model_reset();
        m_per = '0; m_cnt = '0; m_ctl = '0; m_tgl = 1'b0; m_cnting = 1'b0;
        for (int i = 0; i < 3; i++) m_cmp[i] = '0;
    endtask

    task automatic model_step();
        logic [W-1:0] nxt;
        if (!m_cnting && wr_en) begin
            case (wr_addr)
                3'd0: m_per = wr_data;
                3'd1: m_cmp[0] = wr_data;
                3'd2: m_cmp[1] = wr_data;
                3'd3: m_cmp[2] = wr_data;
                3'd4: m_ctl = wr_data[8:0];
                3'd5: m_cnt = wr_data;
                default: ;
            endcase
        end else if (m_cnting && tick) begin
            nxt = (m_cnt == m_per) ? '0 : m_cnt + 16'd1;
            if (nxt == m_per) m_tgl = ~m_tgl;
            m_cnt = nxt;
        end
        m_cnting = run;
    endtask

    task automatic check(input string tag);
        logic [6:0] e, a;
        e = exp_out();
        a = {ph_p, ph_n, tgl_o};
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: got p=%b n=%b t=%b expected p=%b n=%b t=%b",
                     tag, a[6:4], a[3:1], a[0], e[6:4], e[3:1], e[0]);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(tag);
        wr_en = 1'b0;
    endtask

    task automatic halt_now(input string tag);
        run = 1'b0; tick = 1'b0;
        cyc(tag);
    endtask

    task automatic setup(input logic [W-1:0] per, input logic [W-1:0] c0,
                         input logic [W-1:0] c1, input logic [W-1:0] c2,
                         input logic [8:0] ctl, input logic [W-1:0] ld);
        wr(3'd0, per, "R6");
        wr(3'd1, c0, "R6");
        wr(3'd2, c1, "R6");
        wr(3'd3, c2, "R6");
        wr(3'd4, {7'd0, ctl}, "R9");
        wr(3'd5, ld, "R7");
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        model_reset();
        #9 rst_n = 1'b1;
        @(negedge clk);
        check("R11");  // reset state
        cyc("R11");

        // compares at 0, mid and period; all pins on, both levels high, toggle on
        setup(16'd5, 16'd0, 16'd2, 16'd5, 9'h1FF, 16'd0);
        check("R3");
        run = 1'b1; tick = 1'b1;
        for (int k = 0; k < 14; k++) cyc((k % 2) ? "R1" : "R3");
        for (int k = 0; k < 14; k++) cyc("R2");

        // sparse tick
        for (int k = 0; k < 16; k++) begin
            tick = (k % 3 == 0);
            cyc("R4");
        end
        tick = 1'b1;

        // writes in COUNT must be dropped
        wr(3'd0, 16'd2, "R6");
        wr(3'd2, 16'd0, "R6");
        wr(3'd4, 16'h000, "R6");
        wr(3'd5, 16'd4, "R6");
        for (int k = 0; k < 12; k++) cyc("R6");

        // halt: nothing moves
        halt_now("R5");
        tick = 1'b1;
        for (int k = 0; k < 6; k++) cyc("R5");

        // load counter, restart
        wr(3'd5, 16'd3, "R7");
        check("R7");
        run = 1'b1;
        for (int k = 0; k < 8; k++) cyc("R5");

        // toggle disabled, then re-enabled
        halt_now("R8");
        wr(3'd4, 16'h1FE, "R8");
        run = 1'b1;
        for (int k = 0; k < 10; k++) cyc("R8");
        halt_now("R8");
        wr(3'd4, 16'h1FF, "R8");
        run = 1'b1;
        for (int k = 0; k < 10; k++) cyc("R8");

        // active-low levels, mixed
        halt_now("R9");
        wr(3'd4, 16'h1FB, "R9");
        run = 1'b1;
        for (int k = 0; k < 12; k++) cyc("R9");
        halt_now("R9");
        wr(3'd4, 16'h1F9, "R9");
        run = 1'b1;
        for (int k = 0; k < 12; k++) cyc("R9");

        // some pins disabled
        halt_now("R10");
        wr(3'd4, 16'h0AF, "R10");
        run = 1'b1;
        for (int k = 0; k < 12; k++) cyc("R10");
        halt_now("R10");
        wr(3'd4, 16'h147, "R10");
        run = 1'b1;
        for (int k = 0; k < 12; k++) cyc("R10");

        // random rounds
        for (int r = 0; r < 60; r++) begin
            logic [W-1:0] per, ld;
            logic [W-1:0] c [3];
            int dens, len;
            halt_now("R2");
            per = W'($urandom_range(0, 20));
            for (int i = 0; i < 3; i++) begin
                case ($urandom_range(0, 3))
                    0: c[i] = '0;
                    1: c[i] = per;
                    default: c[i] = W'($urandom_range(0, int'(per)));
                endcase
            end
            ld = ($urandom_range(0, 4) == 0) ? W'($urandom_range(0, 25)) : '0;
            setup(per, c[0], c[1], c[2], 9'($urandom_range(0, 511)), ld);
            dens = $urandom_range(1, 4);
            len  = $urandom_range(20, 80);
            run = 1'b1;
            for (int k = 0; k < len; k++) begin
                tick = ($urandom_range(1, dens) == 1);
                if ($urandom_range(0, 15) == 0) begin
                    wr_en = 1'b1;
                    wr_addr = 3'($urandom_range(0, 5));
                    wr_data = W'($urandom_range(0, 30));
                end
                cyc("R2");
                wr_en = 1'b0;
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule